// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Drive Generator

This block drives up to six power-stage phases. Each phase has a high-side drive and a low-side drive. One free-running period counter sets the switching period. The start of each phase is offset from phase 0 by an equal share of that period. When a phase reaches the start of its own cycle, it captures the shared duty command word. It then produces a high-side pulse whose length in clock cycles equals that captured value, limited so that both dead bands still fit in the period. The low-side drive is the non-overlapping complement of the high-side pulse. A programmable number of cycles, with both drives low, separates every hand-over between the two drives.

A single enable input allows switching, and a fault input stops it. While either one blocks operation, every drive is held low in the same cycle and the timing state returns to its start. A power-good output rises only after a regulation-ok input has stayed true for a programmed number of complete periods while switching is allowed. It falls as soon as switching stops or regulation-ok drops.

Top module: `mpwm_gen`

## Requirements
- R1: The effective period P is `period_cfg`, with values below 2 treated as 2. The period counter steps through 0 to P-1 and then wraps, so each active phase's high-side drive rises once every P cycles.
- R2: The effective phase count N is `phase_cnt`, with 0 treated as 1 and values above 6 treated as 6. Phases with index N or higher hold both drives low.
- R3: Phase k (k < N) has offset floor(P*k/N). Its local position is (counter - offset) mod P, so its high-side rising edge follows phase 0's by exactly that offset.
- R4: When a phase's local position is 0, it captures `duty_cmd` and clamps it to W = min(duty, max(P - 2*D, 0)), where D is `dead_cfg`. Changes of `duty_cmd` at any other position do not affect that phase's pulse. Before a phase's first capture, W is 0.
- R5: The drive outputs are registered. The values seen after a clock edge reflect the counter value held before that edge. High side is on for D <= pos < D+W. Low side is on for pos >= W + 2*D.
- R6: The two drives of a phase are never high together. Every hand-over between them has D cycles with both drives low.
- R7: When `out_en` is low or `fault` is high, all drives are low in that same cycle, and the counter and captured widths clear. The first enabled edge processes counter value 0.
- R8: `pwr_good` is low in any cycle where `out_en` is low or `fault` is high.
- R9: While switching is allowed and `reg_ok` is high at each edge, a count of completed periods (saturating at 2^PG_W-1) grows by one at each wrap. `pwr_good` rises at the edge where this count reaches `pg_delay`. An edge with `reg_ok` low clears both the count and `pwr_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_en | input | 1 | Switching enable |
| fault | input | 1 | Major fault, forces all drives off |
| reg_ok | input | 1 | Output regulation within limits |
| period_cfg | input | CNT_W | Switching period in clock cycles |
| phase_cnt | input | PH_W | Number of active phases |
| dead_cfg | input | DT_W | Dead time in clock cycles |
| duty_cmd | input | CNT_W | Shared duty command, in clock cycles of high-side on-time |
| pg_delay | input | PG_W | Periods of good regulation before power-good |
| hs_out | output | MAX_PH | High-side drive per phase |
| ls_out | output | MAX_PH | Low-side drive per phase |
| pwr_good | output | 1 | Power-good status |

## Verification
Some properties are checked on every cycle by assertions: the two drives of a phase never overlap, unused phases stay silent, enable and fault force the drives and power-good low, the counter stays inside the period and returns to zero after a wrap, and power-good never rises without regulation-ok present in the previous cycle. Other behaviour can only be shown by the bench's scenarios, which compare every output against a cycle-stepped model. These are the exact phase spacing for phase counts that do not divide the period, capture of the duty word only at each phase's start, clamping when dead time eats the period, restart timing after enable, and the delayed rise of power-good.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  // Phase count after clamping into 1..maxp
  function automatic int unsigned eff_phases(input int unsigned req, input int unsigned maxp);
    if (req == 0) return 1;
    if (req > maxp) return maxp;
    return req;
  endfunction

  // Period in cycles, never below two
  function automatic int unsigned eff_period(input int unsigned req);
    return (req < 2) ? 2 : req;
  endfunction

  // Start offset of phase k among n phases over period p
  function automatic int unsigned phase_offset(input int unsigned p, input int unsigned k,
                                               input int unsigned n);
    return (p * k) / n;
  endfunction

  // Largest high-side time that leaves room for both dead bands
  function automatic int unsigned width_cap(input int unsigned p, input int unsigned d);
    return (p > 2 * d) ? (p - 2 * d) : 0;
  endfunction

  function automatic int unsigned clamp_width(input int unsigned duty, input int unsigned cap);
    return (duty < cap) ? duty : cap;
  endfunction

  // Position of a phase inside its own cycle
  function automatic int unsigned local_pos(input int unsigned cnt, input int unsigned off,
                                            input int unsigned p);
    return (cnt >= off) ? (cnt - off) : (cnt + p - off);
  endfunction

  function automatic logic hi_window(input int unsigned pos, input int unsigned d,
                                     input int unsigned w);
    return (pos >= d) && (pos < d + w);
  endfunction

  function automatic logic lo_window(input int unsigned pos, input int unsigned d,
                                     input int unsigned w);
    return pos >= (w + 2 * d);
  endfunction

endpackage

// File: rtl/mpwm_period_timer.sv
module mpwm_period_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  assign wrap = active && (cnt_q >= period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mpwm_phase_chan.sv
module mpwm_phase_chan
  import mpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] offset,
  input  logic [DT_W-1:0]  dead,
  input  logic [CNT_W-1:0] duty,
  output logic             hs_q,
  output logic             ls_q
);

  logic [CNT_W-1:0] w_q;
  int unsigned      pos;
  int unsigned      cap;
  int unsigned      w_new;
  int unsigned      w_use;
  logic             start_evt;

  always_comb begin
    pos       = local_pos(32'(cnt), 32'(offset), 32'(period));
    cap       = width_cap(32'(period), 32'(dead));
    w_new     = clamp_width(32'(duty), cap);
    start_evt = run && (pos == 0);
    w_use     = start_evt ? w_new : 32'(w_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else if (!run) begin
      w_q  <= '0;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      if (start_evt) w_q <= CNT_W'(w_new);
      hs_q <= hi_window(pos, 32'(dead), w_use);
      ls_q <= lo_window(pos, 32'(dead), w_use);
    end
  end

endmodule

// File: rtl/mpwm_pgood.sv
module mpwm_pgood #(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            reg_ok,
  input  logic            wrap,
  input  logic [PG_W-1:0] delay,
  output logic            pg_q
);

  logic [PG_W-1:0] per_cnt;
  logic [PG_W-1:0] per_nxt;

  always_comb begin
    per_nxt = per_cnt;
    if (wrap && (per_cnt != {PG_W{1'b1}})) per_nxt = per_cnt + PG_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      pg_q    <= 1'b0;
    end else if (!active || !reg_ok) begin
      per_cnt <= '0;
      pg_q    <= 1'b0;
    end else begin
      per_cnt <= per_nxt;
      pg_q    <= (per_nxt >= delay);
    end
  end

endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen
  import mpwm_pkg::*;
#(
  parameter int MAX_PH = 6,
  parameter int CNT_W  = 12,
  parameter int DT_W   = 6,
  parameter int PG_W   = 8,
  localparam int PH_W  = $clog2(MAX_PH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic              fault,
  input  logic              reg_ok,
  input  logic [CNT_W-1:0]  period_cfg,
  input  logic [PH_W-1:0]   phase_cnt,
  input  logic [DT_W-1:0]   dead_cfg,
  input  logic [CNT_W-1:0]  duty_cmd,
  input  logic [PG_W-1:0]   pg_delay,
  output logic [MAX_PH-1:0] hs_out,
  output logic [MAX_PH-1:0] ls_out,
  output logic              pwr_good
);

  logic              active;
  logic [CNT_W-1:0]  period_eff;
  logic [PH_W-1:0]   n_eff;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_evt;
  logic [MAX_PH-1:0] in_use;
  logic [MAX_PH-1:0] hs_q;
  logic [MAX_PH-1:0] ls_q;
  logic              pg_q;

  assign active     = out_en & ~fault;
  assign period_eff = CNT_W'(eff_period(32'(period_cfg)));
  assign n_eff      = PH_W'(eff_phases(32'(phase_cnt), MAX_PH));

  mpwm_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .period (period_eff),
    .cnt_q  (cnt_q),
    .wrap   (wrap_evt)
  );

  for (genvar k = 0; k < MAX_PH; k++) begin : g_phase
    logic [CNT_W-1:0] offset;
    assign offset    = CNT_W'(phase_offset(32'(period_eff), k, 32'(n_eff)));
    assign in_use[k] = (32'(n_eff) > k);

    mpwm_phase_chan #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (active & in_use[k]),
      .cnt    (cnt_q),
      .period (period_eff),
      .offset (offset),
      .dead   (dead_cfg),
      .duty   (duty_cmd),
      .hs_q   (hs_q[k]),
      .ls_q   (ls_q[k])
    );
  end

  mpwm_pgood #(.PG_W(PG_W)) u_pgood (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .reg_ok (reg_ok),
    .wrap   (wrap_evt),
    .delay  (pg_delay),
    .pg_q   (pg_q)
  );

  assign hs_out   = hs_q & {MAX_PH{active}};
  assign ls_out   = ls_q & {MAX_PH{active}};
  assign pwr_good = pg_q & active;

endmodule

// File: rtl/mpwm_gen_chk.sv
module mpwm_gen_chk #(
  parameter int MAX_PH = 6,
  parameter int CNT_W  = 12,
  parameter int PH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_en,
  input logic              fault,
  input logic              reg_ok,
  input logic [PH_W-1:0]   phase_cnt,
  input logic [MAX_PH-1:0] hs_out,
  input logic [MAX_PH-1:0] ls_out,
  input logic              pwr_good,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              wrap_evt,
  input logic [CNT_W-1:0]  period_eff
);

  logic [MAX_PH-1:0] used_mask;

  always_comb begin
    used_mask = '0;
    for (int k = 0; k < MAX_PH; k++) begin
      if (k == 0 || k < int'(phase_cnt)) used_mask[k] = 1'b1;
    end
  end

  // R6
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_out & ls_out) == '0);

  // R7
  a_r7_drives_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || fault) |-> (hs_out == '0 && ls_out == '0));

  // R8
  a_r8_pg_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en || fault) |-> !pwr_good);

  // R2
  a_r2_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(phase_cnt) |-> (((hs_out | ls_out) & ~used_mask) == '0));

  // R1
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0));

  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(period_eff) |-> (cnt_q < period_eff));

  // R9
  a_r9_pg_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(reg_ok));

endmodule

bind mpwm_gen mpwm_gen_chk #(
  .MAX_PH (MAX_PH),
  .CNT_W  (CNT_W),
  .PH_W   (PH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_en     (out_en),
  .fault      (fault),
  .reg_ok     (reg_ok),
  .phase_cnt  (phase_cnt),
  .hs_out     (hs_out),
  .ls_out     (ls_out),
  .pwr_good   (pwr_good),
  .cnt_q      (cnt_q),
  .wrap_evt   (wrap_evt),
  .period_eff (period_eff)
);

// File: tb/mpwm_gen_tb.sv
module mpwm_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 6;
  localparam int CW   = 12;
  localparam int DW   = 6;
  localparam int GW   = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          out_en, fault, reg_ok;
  logic [CW-1:0] period_cfg, duty_cmd;
  logic [2:0]    phase_cnt;
  logic [DW-1:0] dead_cfg;
  logic [GW-1:0] pg_delay;
  logic [MAXP-1:0] hs_out, ls_out;
  logic          pwr_good;

  mpwm_gen u_dut (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .fault(fault), .reg_ok(reg_ok),
    .period_cfg(period_cfg), .phase_cnt(phase_cnt), .dead_cfg(dead_cfg),
    .duty_cmd(duty_cmd), .pg_delay(pg_delay),
    .hs_out(hs_out), .ls_out(ls_out), .pwr_good(pwr_good)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic [MAXP-1:0] hs;
    logic [MAXP-1:0] ls;
    logic            pg;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string cur_req = "R7";

  // reference state, stepped once per rising edge
  int          m_cnt = 0;
  int          m_w[MAXP];
  logic [MAXP-1:0] m_hs = '0, m_ls = '0;
  int          m_pc = 0;
  logic        m_pg = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // driver side of the scoreboard: model pushes expected register state
  always @(posedge clk) begin : ref_model
    int P, N, D, cap, off, pos;
    logic act, wr;
    exp_t e;
    cyc++;
    act = out_en && !fault;
    if (!rst_n || !act) begin
      m_cnt = 0;
      for (int k = 0; k < MAXP; k++) m_w[k] = 0;
      m_hs = '0; m_ls = '0; m_pc = 0; m_pg = 1'b0;
    end else begin
      P = (int'(period_cfg) < 2) ? 2 : int'(period_cfg);
      N = (phase_cnt == 0) ? 1 : ((int'(phase_cnt) > MAXP) ? MAXP : int'(phase_cnt));
      D = int'(dead_cfg);
      cap = P - 2 * D;
      if (cap < 0) cap = 0;
      for (int k = 0; k < MAXP; k++) begin
        if (k >= N) begin
          m_w[k] = 0; m_hs[k] = 1'b0; m_ls[k] = 1'b0;
        end else begin
          off = (P * k) / N;
          pos = (m_cnt - off + P) % P;
          if (pos == 0) m_w[k] = (int'(duty_cmd) < cap) ? int'(duty_cmd) : cap;
          m_hs[k] = (pos >= D) && (pos < D + m_w[k]);
          m_ls[k] = (pos >= m_w[k] + 2 * D);
        end
      end
      wr = (m_cnt == P - 1);
      if (reg_ok) begin
        if (wr && m_pc < 255) m_pc++;
        m_pg = (m_pc >= int'(pg_delay));
      end else begin
        m_pc = 0; m_pg = 1'b0;
      end
      m_cnt = wr ? 0 : m_cnt + 1;
    end
    e.hs = m_hs; e.ls = m_ls; e.pg = m_pg;
    sb_q.push_back(e);
  end

  // monitor side: pop and compare away from the clock edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic a;
      e = sb_q.pop_front();
      a = out_en && !fault;
      chk(cur_req, "hs_out", 32'(hs_out), 32'(e.hs & {MAXP{a}}));
      chk(cur_req, "ls_out", 32'(ls_out), 32'(e.ls & {MAXP{a}}));
      chk(cur_req, "pwr_good", 32'(pwr_good), 32'(e.pg & a));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic configure(input int p, input int n, input int d, input int du,
                           input int pgd, output int t_en);
    out_en = 1'b0;
    step(2);
    period_cfg = CW'(p); phase_cnt = 3'(n); dead_cfg = DW'(d);
    duty_cmd = CW'(du); pg_delay = GW'(pgd);
    out_en = 1'b1;
    t_en = cyc;
  endtask

  task automatic wait_rise(input int k, output int t);
    logic prev;
    prev = hs_out[k];
    forever begin
      @(negedge clk);
      if (hs_out[k] && !prev) begin
        t = cyc;
        return;
      end
      prev = hs_out[k];
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, te, acc, ovl;
    rst_n = 1'b0; out_en = 1'b0; fault = 1'b0; reg_ok = 1'b1;
    period_cfg = 12; phase_cnt = 3; dead_cfg = 1; duty_cmd = 4; pg_delay = 2;
    step(4);
    @(negedge clk);
    chk("R7", "reset drives", 32'({hs_out, ls_out}), 0);
    chk("R8", "reset pwr_good", 32'(pwr_good), 0);
    rst_n = 1'b1;
    step(1);

    // R1 R3 R5: three phases over twelve cycles
    cur_req = "R5";
    configure(12, 3, 1, 4, 2, te);
    wait_rise(0, t0); wait_rise(0, t1);
    chk("R1", "phase0 period", 32'(t1 - t0), 12);
    wait_rise(1, t2);
    chk("R3", "phase1 lag", 32'(t2 - t1), 4);
    wait_rise(2, t3);
    chk("R3", "phase2 lag", 32'(t3 - t2), 4);
    step(30);

    // R1: period below two behaves as two
    cur_req = "R1";
    configure(1, 1, 0, 1, 0, te);
    wait_rise(0, t0); wait_rise(0, t1);
    chk("R1", "min period", 32'(t1 - t0), 2);
    step(10);

    // R2: phase count clamping, uneven offsets
    cur_req = "R2";
    configure(13, 0, 2, 3, 1, te);
    step(40);
    @(negedge clk);
    chk("R2", "unused phases", 32'({hs_out[5:1], ls_out[5:1]}), 0);
    configure(13, 7, 1, 2, 1, te);
    step(20);
    acc = 0;
    repeat (13) begin @(negedge clk); acc |= int'(hs_out); end
    chk("R2", "six phases fire", 32'(acc), 32'h3f);
    step(30);

    // R4: clamp of the captured width
    cur_req = "R4";
    configure(10, 2, 2, 100, 1, te);
    wait_rise(0, t0);
    acc = 1;
    forever begin @(negedge clk); if (!hs_out[0]) break; acc++; end
    chk("R4", "clamped width", 32'(acc), 6);
    step(20);
    configure(10, 1, 5, 3, 1, te);
    acc = 0;
    repeat (30) begin @(negedge clk); acc |= int'(hs_out); end
    chk("R4", "no room for pulse", 32'(acc), 0);

    // R4: duty moving mid-period is only taken at each phase start
    configure(16, 4, 1, 5, 1, te);
    for (int i = 0; i < 120; i++) begin
      duty_cmd = CW'((i * 7) % 14);
      step(1);
    end

    // R6: dead time zero and wide dead time
    cur_req = "R6";
    ovl = 0;
    configure(9, 3, 0, 4, 1, te);
    repeat (40) begin @(negedge clk); if ((hs_out & ls_out) != 0) ovl++; end
    configure(20, 2, 3, 7, 1, te);
    repeat (60) begin @(negedge clk); if ((hs_out & ls_out) != 0) ovl++; end
    chk("R6", "overlap count", 32'(ovl), 0);

    // R7 R8: fault and enable gating
    cur_req = "R7";
    configure(12, 6, 1, 5, 1, te);
    step(40);
    fault = 1'b1;
    @(negedge clk);
    chk("R7", "drives under fault", 32'({hs_out, ls_out}), 0);
    chk("R8", "pwr_good under fault", 32'(pwr_good), 0);
    step(5);
    fault = 1'b0;
    step(30);
    out_en = 1'b0;
    @(negedge clk);
    chk("R7", "drives disabled", 32'({hs_out, ls_out}), 0);
    chk("R8", "pwr_good disabled", 32'(pwr_good), 0);
    step(3);
    out_en = 1'b1;
    te = cyc;
    wait_rise(0, t0);
    chk("R7", "restart latency", 32'(t0 - te), 2);
    step(20);

    // R9: power-good delay and drop on reg_ok
    cur_req = "R9";
    configure(10, 2, 0, 3, 3, te);
    forever begin @(negedge clk); if (pwr_good) break; end
    chk("R9", "pwr_good rise cycle", 32'(cyc - te), 30);
    step(5);
    reg_ok = 1'b0;
    step(1);
    @(negedge clk);
    chk("R9", "pwr_good after reg_ok low", 32'(pwr_good), 0);
    step(2);
    reg_ok = 1'b1;
    step(50);

    out_en = 1'b0;
    step(3);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule